// File: doc/BRIEF.md
# 1-Wire Slave ROM-Command Layer

This block is the addressing layer of a single-device 1-Wire slave. A bit-level slot engine below it delivers whole received bytes, single received bits, a pulse for each detected bus reset (reset pulse with presence already answered), and it accepts bytes or single bits for transmission. After each bus reset the layer takes one command byte and runs the matching addressing procedure against a 64-bit device identifier. These procedures are read identifier, compare identifier, skip addressing, binary-tree search and fast re-address. When addressing succeeds, it raises a one-cycle select strobe and holds a memory-phase enable for the memory-function layer until the next bus reset.

A sticky re-address flag remembers that this device was the last one picked out by an identifier compare or a search. While the flag is set, the one-byte fast re-address command selects the device without any identifier traffic. A failed compare or search means some other device is being addressed, so the flag is cleared then. The flag survives bus resets and is cleared only by such a failure or by the power-up reset `rst_n`.

Top module: `owrc_top`

## Requirements
- R1: After `rst_n`, all outputs are low, and command bytes are ignored until the first `bus_reset_i` pulse.
- R2: Command 0xCC selects at once, and the re-address flag is left as it was.
- R3: Command 0x33 sends the eight identifier bytes on the byte channel, lowest byte first (byte k = ID bits 8k+7..8k), each held until `tx_ready_i`. It then selects, and the flag is left as it was. The byte and bit transmit channels are never valid together.
- R4: Command 0x55 compares the next eight received bytes with the identifier, lowest byte first. A full match sets the flag and selects.
- R5: A mismatching byte during 0x55 clears the flag. The layer then stays silent and unselected until the next bus reset.
- R6: Command 0xF0 runs for ID bit i = 0..63. It offers bit i on the bit channel, then its complement, then waits for one received direction bit. If all 64 directions equal the ID bits, the flag is set and the device is selected.
- R7: A direction bit that differs from the ID bit clears the flag and stops all bit output until the next bus reset.
- R8: Command 0xA5 selects when the flag is set. When the flag is clear the layer stays silent until the next bus reset.
- R9: Any other command code leaves the layer silent, ignoring all bytes, until the next bus reset.
- R10: A `bus_reset_i` pulse aborts any phase, drops the enable and returns to command wait on the next cycle. The flag is kept. A reset takes priority over a byte or bit arriving in the same cycle.
- R11: `sel_o` is high for exactly the first cycle in which `mem_en_o` is high. `mem_en_o` then stays high, ignoring further bytes, until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset detected |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Byte to send is valid |
| tx_byte_o | output | 8 | Byte to send |
| tx_ready_i | input | 1 | Slot engine took the byte |
| bit_tx_valid_o | output | 1 | Bit to send is valid |
| bit_tx_o | output | 1 | Bit to send |
| bit_tx_ready_i | input | 1 | Slot engine took the bit |
| bit_rx_valid_i | input | 1 | Received bit strobe |
| bit_rx_i | input | 1 | Received bit |
| rom_id_i | input | 64 | Device identifier |
| sel_o | output | 1 | One-cycle select strobe |
| mem_en_o | output | 1 | Memory-function phase enable |

## Verification
A bus reset and a data strobe can meet in one cycle. Examples are a command byte arriving with a reset, and a search direction bit arriving with a reset. The bench drives both strobes on the same clock edge in directed cases. It then checks that the layer is back in command wait, unselected and idle, and that the re-address flag is unchanged. The flag is then probed with a 0xA5 command after a further reset. Randomised command sequences with injected mismatches at random byte or bit positions are compared against a bench model of the flag.

// File: rtl/owrc_pkg.sv
package owrc_pkg;
  localparam int ID_W     = 64;
  localparam int ID_BYTES = ID_W / 8;
  localparam int IDX_W    = $clog2(ID_W);

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
  localparam logic [7:0] OP_RESUME = 8'hA5;

  typedef enum logic [2:0] {
    CMD_READ, CMD_MATCH, CMD_SKIP, CMD_SEARCH, CMD_RESUME, CMD_OTHER
  } cmd_e;

  typedef enum logic [3:0] {
    ST_DORMANT, ST_CMD, ST_MATCH, ST_READ,
    ST_SRCH_T, ST_SRCH_C, ST_SRCH_D, ST_MEM, ST_MUTE
  } st_e;

  // byte k of the identifier, lowest byte first
  function automatic logic [7:0] id_byte(logic [ID_W-1:0] id, logic [IDX_W-1:0] k);
    return 8'(id >> (32'(k) * 8));
  endfunction

  function automatic logic id_bit(logic [ID_W-1:0] id, logic [IDX_W-1:0] k);
    return id[k];
  endfunction
endpackage

// File: rtl/owrc_decode.sv
module owrc_decode
  import owrc_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       cmd_o
);
  always_comb begin
    unique case (code_i)
      OP_READ:   cmd_o = CMD_READ;
      OP_MATCH:  cmd_o = CMD_MATCH;
      OP_SKIP:   cmd_o = CMD_SKIP;
      OP_SEARCH: cmd_o = CMD_SEARCH;
      OP_RESUME: cmd_o = CMD_RESUME;
      default:   cmd_o = CMD_OTHER;
    endcase
  end
endmodule

// File: rtl/owrc_rcflag.sv
module owrc_rcflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic rc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rc_o <= 1'b0;
    else if (clr_i) rc_o <= 1'b0;
    else if (set_i) rc_o <= 1'b1;
  end
endmodule

// File: rtl/owrc_seq.sv
module owrc_seq
  import owrc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_byte_i,
  input  cmd_e            cmd_i,
  input  logic            tx_ready_i,
  input  logic            bit_tx_ready_i,
  input  logic            bit_rx_valid_i,
  input  logic            bit_rx_i,
  input  logic [ID_W-1:0] rom_id_i,
  input  logic            rc_i,
  output logic            tx_valid_o,
  output logic [7:0]      tx_byte_o,
  output logic            bit_tx_valid_o,
  output logic            bit_tx_o,
  output logic            mem_en_o,
  output logic            sel_o,
  output logic            rc_set_o,
  output logic            rc_clr_o
);
  localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(ID_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(ID_W - 1);

  st_e              st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             cur_bit;
  logic [7:0]       cur_byte;

  assign cur_bit  = id_bit(rom_id_i, cnt_q);
  assign cur_byte = id_byte(rom_id_i, cnt_q);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    rc_set_o = 1'b0;
    rc_clr_o = 1'b0;
    if (bus_reset_i) begin
      st_d  = ST_CMD;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_CMD: if (rx_valid_i) begin
          unique case (cmd_i)
            CMD_SKIP:   st_d = ST_MEM;
            CMD_READ:   st_d = ST_READ;
            CMD_MATCH:  st_d = ST_MATCH;
            CMD_SEARCH: st_d = ST_SRCH_T;
            CMD_RESUME: st_d = rc_i ? ST_MEM : ST_MUTE;
            default:    st_d = ST_MUTE;
          endcase
        end
        ST_MATCH: if (rx_valid_i) begin
          if (rx_byte_i != cur_byte) begin
            rc_clr_o = 1'b1;
            st_d     = ST_MUTE;
          end else if (cnt_q == LAST_BYTE) begin
            rc_set_o = 1'b1;
            st_d     = ST_MEM;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_READ: if (tx_ready_i) begin
          if (cnt_q == LAST_BYTE) st_d = ST_MEM;
          else                    cnt_d = cnt_q + 1'b1;
        end
        ST_SRCH_T: if (bit_tx_ready_i) st_d = ST_SRCH_C;
        ST_SRCH_C: if (bit_tx_ready_i) st_d = ST_SRCH_D;
        ST_SRCH_D: if (bit_rx_valid_i) begin
          if (bit_rx_i != cur_bit) begin
            rc_clr_o = 1'b1;
            st_d     = ST_MUTE;
          end else if (cnt_q == LAST_BIT) begin
            rc_set_o = 1'b1;
            st_d     = ST_MEM;
          end else begin
            cnt_d = cnt_q + 1'b1;
            st_d  = ST_SRCH_T;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_DORMANT;
      cnt_q <= '0;
      sel_o <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sel_o <= (st_d == ST_MEM) && (st_q != ST_MEM);
    end
  end

  assign tx_valid_o     = (st_q == ST_READ);
  assign tx_byte_o      = tx_valid_o ? cur_byte : 8'h00;
  assign bit_tx_valid_o = (st_q == ST_SRCH_T) || (st_q == ST_SRCH_C);
  assign bit_tx_o       = (st_q == ST_SRCH_T) ? cur_bit :
                          (st_q == ST_SRCH_C) ? ~cur_bit : 1'b0;
  assign mem_en_o       = (st_q == ST_MEM);
endmodule

// File: rtl/owrc_top.sv
module owrc_top
  import owrc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset_i,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_byte_i,
  output logic            tx_valid_o,
  output logic [7:0]      tx_byte_o,
  input  logic            tx_ready_i,
  output logic            bit_tx_valid_o,
  output logic            bit_tx_o,
  input  logic            bit_tx_ready_i,
  input  logic            bit_rx_valid_i,
  input  logic            bit_rx_i,
  input  logic [ID_W-1:0] rom_id_i,
  output logic            sel_o,
  output logic            mem_en_o
);
  cmd_e cmd_w;
  logic rc_w, rc_set_w, rc_clr_w;

  owrc_decode u_dec (.code_i(rx_byte_i), .cmd_o(cmd_w));

  owrc_rcflag u_rc (
    .clk(clk), .rst_n(rst_n), .set_i(rc_set_w), .clr_i(rc_clr_w), .rc_o(rc_w)
  );

  owrc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
    .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .cmd_i(cmd_w),
    .tx_ready_i(tx_ready_i), .bit_tx_ready_i(bit_tx_ready_i),
    .bit_rx_valid_i(bit_rx_valid_i), .bit_rx_i(bit_rx_i),
    .rom_id_i(rom_id_i), .rc_i(rc_w),
    .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
    .bit_tx_valid_o(bit_tx_valid_o), .bit_tx_o(bit_tx_o),
    .mem_en_o(mem_en_o), .sel_o(sel_o),
    .rc_set_o(rc_set_w), .rc_clr_o(rc_clr_w)
  );
endmodule

// File: rtl/owrc_checker.sv
module owrc_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_reset_i,
  input logic tx_valid_o,
  input logic bit_tx_valid_o,
  input logic sel_o,
  input logic mem_en_o,
  input logic rc_w
);
  assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (!mem_en_o && !tx_valid_o && !bit_tx_valid_o));

  assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid_o && bit_tx_valid_o));

  assert_sel_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |=> !sel_o);

  assert_sel_in_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o |-> mem_en_o);

  assert_mem_entry_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en_o) |-> sel_o);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !bus_reset_i) |=> mem_en_o);

  assert_flag_set_selects_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_w) |-> sel_o);

  assert_flag_clear_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_w) |-> !mem_en_o);
endmodule

bind owrc_top owrc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i),
  .tx_valid_o(tx_valid_o), .bit_tx_valid_o(bit_tx_valid_o),
  .sel_o(sel_o), .mem_en_o(mem_en_o), .rc_w(rc_w)
);

// File: tb/owrc_top_bench.sv
module owrc_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_byte_i = 8'h00;
  logic        tx_valid_o;
  logic [7:0]  tx_byte_o;
  logic        tx_ready_i = 1'b0;
  logic        bit_tx_valid_o;
  logic        bit_tx_o;
  logic        bit_tx_ready_i = 1'b0;
  logic        bit_rx_valid_i = 1'b0;
  logic        bit_rx_i = 1'b0;
  logic [63:0] rom_id_i = 64'h0;
  logic        sel_o;
  logic        mem_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit rc_m  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owrc_top u_owrc_top (.*);

  function automatic logic [7:0] exp_byte(logic [63:0] id, int k);
    return (id >> (k * 8)) & 64'hFF;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic bus_rst();
    bus_reset_i = 1'b1; tick(); bus_reset_i = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid_i = 1'b1; rx_byte_i = b; tick(); rx_valid_i = 1'b0;
  endtask

  task automatic probe_flag();
    bus_rst();
    send_byte(8'hA5);
    chk("R8 resume follows flag", mem_en_o, rc_m);
    if (rc_m) chk("R8/R11 resume strobe", sel_o, 1);
  endtask

  task automatic do_skip();
    send_byte(8'hCC);
    chk("R2 skip selects", mem_en_o, 1);
    chk("R11 strobe on entry", sel_o, 1);
    tick();
    chk("R11 strobe one cycle", sel_o, 0);
    send_byte(8'hF0);
    chk("R11 bytes ignored in mem phase", {mem_en_o, bit_tx_valid_o}, 2'b10);
  endtask

  task automatic do_read();
    send_byte(8'h33);
    for (int k = 0; k < 8; k++) begin
      chk("R3 tx valid", tx_valid_o, 1);
      chk("R3 tx byte", tx_byte_o, exp_byte(rom_id_i, k));
      if (k == 3) begin tick(); chk("R3 held until ready", tx_byte_o, exp_byte(rom_id_i, k)); end
      tx_ready_i = 1'b1; tick(); tx_ready_i = 1'b0;
    end
    chk("R3 read selects", {mem_en_o, sel_o, tx_valid_o}, 3'b110);
  endtask

  task automatic do_match(int bad);
    send_byte(8'h55);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] b;
      b = exp_byte(rom_id_i, k);
      if (k == bad) b = b ^ (8'h01 << $urandom_range(0, 7));
      send_byte(b);
      if (k == bad) begin
        rc_m = 1'b0;
        chk("R5 match miss unselected", mem_en_o, 0);
        send_byte(8'hCC);
        chk("R5 silent after miss", mem_en_o, 0);
        return;
      end
    end
    rc_m = 1'b1;
    chk("R4 match selects", {mem_en_o, sel_o}, 2'b11);
  endtask

  task automatic do_search(int bad, int abort_at);
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      logic ib;
      ib = rom_id_i[i];
      chk("R6 true bit", {bit_tx_valid_o, bit_tx_o}, {1'b1, ib});
      bit_tx_ready_i = 1'b1; tick(); bit_tx_ready_i = 1'b0;
      chk("R6 complement bit", {bit_tx_valid_o, bit_tx_o}, {1'b1, ~ib});
      bit_tx_ready_i = 1'b1; tick(); bit_tx_ready_i = 1'b0;
      chk("R6 waits for direction", bit_tx_valid_o, 0);
      bit_rx_valid_i = 1'b1; bit_rx_i = (i == bad) ? ~ib : ib;
      if (i == abort_at) bus_reset_i = 1'b1;
      tick();
      bit_rx_valid_i = 1'b0; bus_reset_i = 1'b0;
      if (i == abort_at) begin
        chk("R10 reset beats direction bit", {mem_en_o, bit_tx_valid_o}, 2'b00);
        return;
      end
      if (i == bad) begin
        rc_m = 1'b0;
        chk("R7 search miss stops", {mem_en_o, bit_tx_valid_o}, 2'b00);
        repeat (3) tick();
        chk("R7 stays silent", bit_tx_valid_o, 0);
        return;
      end
    end
    rc_m = 1'b1;
    chk("R6 search selects", {mem_en_o, sel_o}, 2'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rom_id_i = {$urandom(), $urandom()};
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 outputs low after reset", {tx_valid_o, bit_tx_valid_o, sel_o, mem_en_o}, 0);
    send_byte(8'hCC);
    chk("R1 command ignored before bus reset", mem_en_o, 0);
    probe_flag();
    chk("R1 flag clear at power-up", mem_en_o, 0);

    bus_rst(); do_skip();
    bus_rst(); do_read();
    bus_rst(); do_match(-1);
    probe_flag();
    chk("R10 flag kept over reset", mem_en_o, 1);
    bus_rst(); do_skip();
    probe_flag();
    bus_rst(); do_match(0);
    probe_flag();
    bus_rst(); do_search(-1, -1);
    probe_flag();
    bus_rst(); do_search(63, -1);
    probe_flag();

    // reset and command byte in the same cycle
    bus_rst();
    bus_reset_i = 1'b1; rx_valid_i = 1'b1; rx_byte_i = 8'hCC; tick();
    bus_reset_i = 1'b0; rx_valid_i = 1'b0;
    chk("R10 reset beats command byte", mem_en_o, 0);
    send_byte(8'hCC);
    chk("R10 command wait after collision", mem_en_o, 1);
    bus_rst();
    bus_reset_i = 1'b1; tick(); bus_reset_i = 1'b0;
    chk("R10 reset drops enable", mem_en_o, 0);

    // unknown codes
    bus_rst(); send_byte(8'h0F);
    chk("R9 unknown unselected", mem_en_o, 0);
    send_byte(8'hCC);
    chk("R9 silent until reset", mem_en_o, 0);

    bus_rst(); do_match(-1);
    bus_rst(); do_search(-1, 20);
    probe_flag();

    for (int it = 0; it < 50; it++) begin
      int op;
      op = $urandom_range(0, 6);
      bus_rst();
      case (op)
        0: do_skip();
        1: do_read();
        2: do_match(-1);
        3: do_match($urandom_range(0, 7));
        4: do_search(-1, -1);
        5: do_search($urandom_range(0, 63), -1);
        default: begin
          send_byte(8'hA5);
          chk("R8 resume", mem_en_o, rc_m);
        end
      endcase
      probe_flag();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule